// File: doc/BRIEF.md
# Configuration Request Type Translator

This block lives inside a bridge that joins an upstream (primary) bus to a downstream (secondary) bus. It accepts one configuration request at a time from the upstream side. Each request carries a 32-bit address in the type 1 layout, a read/write flag and write data. The block reads the bus number from the address and compares it against the secondary and subordinate bus numbers that have been programmed into the bridge. From that comparison it picks one of four routes.

If the target sits directly on the secondary bus, the block rewrites the address as a type 0 request. The binary device number becomes a one-hot select on address lines 31:11, so only devices 0 to 20 can be reached. A device number from 21 to 31 has no select line, so the block completes that request itself. If the target lies further downstream, the request passes on unchanged as type 1. Any other request is dropped.

All data-carrying interfaces use valid/ready. A transfer happens on a rising clock edge where both valid and ready are high. Once a valid is raised, it stays high and its payload stays constant until that transfer. The block applies back-pressure upstream by holding `up_req_ready` low while a request is in flight. The sec/sub bus numbers are plain control inputs and must stay static while a request is in flight.

Top module: `cfg_xlate_top`

## Requirements
- R1: After reset, `up_req_ready` is 1 and `dn_req_valid`, `up_rsp_valid` and `dn_rsp_ready` are 0.
- R2: A request is claimed only if address bits 1:0 equal 01. It goes out as type 0 (`dn_req_type1`=0) when the bus number in bits 23:16 equals `sec_bus` and the device number in bits 15:11 is below 21.
- R3: A type 0 address has exactly one of bits 31:11 set, namely bit 11+device. Bits 10:2 (function in 10:8, register in 7:2) are copied from the request, and bits 1:0 are 00.
- R4: `dn_req_write` and `dn_req_wdata` carry the accepted request's write flag and write data unchanged.
- R5: A claimed request whose bus number is greater than `sec_bus` and not greater than `sub_bus` goes out with its address unchanged and `dn_req_type1`=1.
- R6: A claimed request with bus number equal to `sec_bus` and device 21 to 31 issues no downstream request. The next cycle it returns a response with all-ones data, so reads see 0xFFFFFFFF and writes are discarded.
- R7: A request whose bus number lies outside `sec_bus`..`sub_bus`, or whose bits 1:0 differ from 01, is consumed with no downstream request and no response. `up_req_ready` stays 1.
- R8: `up_req_ready` is low from the cycle after a claimed request is accepted until the cycle after its upstream response transfers.
- R9: The data of the downstream response (`dn_rsp_rdata`) is returned on `up_rsp_rdata`. `dn_rsp_ready` is high only while a downstream response is awaited.
- R10: While `dn_req_ready` is low, `dn_req_valid` and its payload hold. While `up_rsp_ready` is low, `up_rsp_valid` and `up_rsp_rdata` hold. The downstream request and the upstream response are never valid together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_bus | input | 8 | Programmed secondary bus number |
| sub_bus | input | 8 | Programmed subordinate bus number |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready |
| up_req_addr | input | 32 | Request address, type 1 layout |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_wdata | input | 32 | Write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_rdata | output | 32 | Response data |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_req_addr | output | 32 | Translated or forwarded address |
| dn_req_type1 | output | 1 | 1 = type 1 request, 0 = type 0 |
| dn_req_write | output | 1 | Write flag of the request |
| dn_req_wdata | output | 32 | Write data of the request |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Downstream response ready |
| dn_rsp_rdata | input | 32 | Downstream response data |

## Verification
The hardest situation to reach is stalling on both handshakes inside a single transaction, which is what exposes a payload that drifts while valid is held. The bench withholds `dn_req_ready` and then `up_rsp_ready` for a cycle each on every forwarded request, and checks that the held payload stays put. The select edges also need care. Device 20 reaches bit 31, device 21 falls back to the local all-ones response, and the bus numbers just outside the range on each side must be dropped. Each of these cases appears as its own row of the vector table.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  typedef enum logic [1:0] {
    ROUTE_DROP  = 2'd0,
    ROUTE_TYPE0 = 2'd1,
    ROUTE_TYPE1 = 2'd2,
    ROUTE_LOCAL = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;
endpackage

// File: rtl/cfg_dev_select.sv
// Binary device number to one-hot select lines; numbers without a line
// report out of range.
module cfg_dev_select #(
  parameter int DEV_W   = 5,
  parameter int NUM_SEL = 21
) (
  input  logic [DEV_W-1:0]   dev,
  output logic [NUM_SEL-1:0] sel,
  output logic               in_range
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign sel[i] = (dev == DEV_W'(i));
  end

  assign in_range = (32'(dev) < NUM_SEL);
endmodule

// File: rtl/cfg_bus_decode.sv
// Classifies a type 1 request against the bridge's bus window.
module cfg_bus_decode
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BUS_W   = 8,
  parameter int BUS_LSB = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  input  logic              dev_in_range,
  output route_e            route
);
  logic [BUS_W-1:0] bus_num;
  logic             fmt_ok;

  assign bus_num = addr[BUS_LSB +: BUS_W];
  assign fmt_ok  = (addr[1:0] == 2'b01);

  always_comb begin
    route = ROUTE_DROP;
    if (fmt_ok) begin
      if (bus_num == sec_bus) begin
        route = dev_in_range ? ROUTE_TYPE0 : ROUTE_LOCAL;
      end else if ((bus_num > sec_bus) && (bus_num <= sub_bus)) begin
        route = ROUTE_TYPE1;
      end
    end
  end
endmodule

// File: rtl/cfg_xlate_ctrl.sv
// One-request-at-a-time sequencer with registered downstream payload.
module cfg_xlate_ctrl
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  route_e            route,
  input  logic [ADDR_W-1:0] type0_addr,
  input  logic [ADDR_W-1:0] type1_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic              dn_req_type1,
  output logic              dn_req_write,
  output logic [DATA_W-1:0] dn_req_wdata,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DATA_W-1:0] dn_rsp_rdata
);
  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              type1_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      type1_q <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (up_req_valid) begin
            unique case (route)
              ROUTE_TYPE0: begin
                addr_q  <= type0_addr;
                type1_q <= 1'b0;
                write_q <= req_write;
                wdata_q <= req_wdata;
                state_q <= ST_ISSUE;
              end
              ROUTE_TYPE1: begin
                addr_q  <= type1_addr;
                type1_q <= 1'b1;
                write_q <= req_write;
                wdata_q <= req_wdata;
                state_q <= ST_ISSUE;
              end
              ROUTE_LOCAL: begin
                rdata_q <= '1;
                state_q <= ST_RESP;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
        ST_ISSUE: if (dn_req_ready) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (dn_rsp_valid) begin
            rdata_q <= dn_rsp_rdata;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: if (up_rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign up_req_ready = (state_q == ST_IDLE);
  assign dn_req_valid = (state_q == ST_ISSUE);
  assign dn_rsp_ready = (state_q == ST_WAIT);
  assign up_rsp_valid = (state_q == ST_RESP);
  assign up_rsp_rdata = rdata_q;
  assign dn_req_addr  = addr_q;
  assign dn_req_type1 = type1_q;
  assign dn_req_write = write_q;
  assign dn_req_wdata = wdata_q;
endmodule

// File: rtl/cfg_xlate_top.sv
module cfg_xlate_top
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int BUS_W   = 8,
  parameter int BUS_LSB = 16,
  parameter int DEV_W   = 5,
  parameter int SEL_LSB = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  input  logic              up_req_valid,
  output logic              up_req_ready,
  input  logic [ADDR_W-1:0] up_req_addr,
  input  logic              up_req_write,
  input  logic [DATA_W-1:0] up_req_wdata,
  output logic              up_rsp_valid,
  input  logic              up_rsp_ready,
  output logic [DATA_W-1:0] up_rsp_rdata,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic [ADDR_W-1:0] dn_req_addr,
  output logic              dn_req_type1,
  output logic              dn_req_write,
  output logic [DATA_W-1:0] dn_req_wdata,
  input  logic              dn_rsp_valid,
  output logic              dn_rsp_ready,
  input  logic [DATA_W-1:0] dn_rsp_rdata
);
  localparam int NUM_SEL = ADDR_W - SEL_LSB;

  logic [DEV_W-1:0]   dev_num;
  logic [NUM_SEL-1:0] dev_sel;
  logic               dev_ok;
  route_e             route;
  logic [ADDR_W-1:0]  type0_addr;

  assign dev_num    = up_req_addr[SEL_LSB +: DEV_W];
  assign type0_addr = {dev_sel, up_req_addr[SEL_LSB-1:2], 2'b00};

  cfg_dev_select #(.DEV_W(DEV_W), .NUM_SEL(NUM_SEL)) u_sel (
    .dev      (dev_num),
    .sel      (dev_sel),
    .in_range (dev_ok)
  );

  cfg_bus_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .BUS_LSB(BUS_LSB)) u_dec (
    .addr         (up_req_addr),
    .sec_bus      (sec_bus),
    .sub_bus      (sub_bus),
    .dev_in_range (dev_ok),
    .route        (route)
  );

  cfg_xlate_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .route        (route),
    .type0_addr   (type0_addr),
    .type1_addr   (up_req_addr),
    .req_write    (up_req_write),
    .req_wdata    (up_req_wdata),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_rdata (up_rsp_rdata),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_addr  (dn_req_addr),
    .dn_req_type1 (dn_req_type1),
    .dn_req_write (dn_req_write),
    .dn_req_wdata (dn_req_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_ready (dn_rsp_ready),
    .dn_rsp_rdata (dn_rsp_rdata)
  );
endmodule

// File: rtl/cfg_xlate_checker.sv
module cfg_xlate_checker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SEL_LSB = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_req_valid,
  input logic              up_req_ready,
  input logic              up_rsp_valid,
  input logic              up_rsp_ready,
  input logic [DATA_W-1:0] up_rsp_rdata,
  input logic              dn_req_valid,
  input logic              dn_req_ready,
  input logic [ADDR_W-1:0] dn_req_addr,
  input logic              dn_req_type1,
  input logic [DATA_W-1:0] dn_req_wdata,
  input logic              dn_rsp_valid,
  input logic              dn_rsp_ready
);
  AST_TYPE0_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_type1 |->
      ($countones(dn_req_addr[ADDR_W-1:SEL_LSB]) == 1) && (dn_req_addr[1:0] == 2'b00)); // R3
  AST_TYPE1_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && dn_req_type1 |-> dn_req_addr[1:0] == 2'b01); // R5
  AST_DN_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=>
      dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_type1) && $stable(dn_req_wdata)); // R10
  AST_UP_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid && !up_rsp_ready |=> up_rsp_valid && $stable(up_rsp_rdata)); // R10
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_req_valid && up_rsp_valid)); // R10
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid || dn_rsp_ready || up_rsp_valid) |-> !up_req_ready); // R8
  AST_RSP_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rsp_ready |-> !dn_req_valid && !up_rsp_valid); // R9
  AST_RELEASE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid && up_rsp_ready |=> up_req_ready); // R8
endmodule

bind cfg_xlate_top cfg_xlate_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_LSB(SEL_LSB)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_req_valid (up_req_valid),
  .up_req_ready (up_req_ready),
  .up_rsp_valid (up_rsp_valid),
  .up_rsp_ready (up_rsp_ready),
  .up_rsp_rdata (up_rsp_rdata),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_req_addr  (dn_req_addr),
  .dn_req_type1 (dn_req_type1),
  .dn_req_wdata (dn_req_wdata),
  .dn_rsp_valid (dn_rsp_valid),
  .dn_rsp_ready (dn_rsp_ready)
);

// File: tb/cfg_xlate_top_tb.sv
module cfg_xlate_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // kind: 0 dropped, 1 type 0, 2 type 1, 3 local all-ones completion
  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  kind;
    logic [31:0] exp_addr;
  } vec_t;

  // sec_bus = 3, sub_bus = 6 for every row
  localparam vec_t VECS [NVEC] = '{
    '{32'h0003_0215, 1'b0, 2'd1, 32'h0000_0A14},  // bus3 dev0 fn2 reg5
    '{32'h0003_A001, 1'b1, 2'd1, 32'h8000_0000},  // dev20 -> bit31
    '{32'h0003_3FFD, 1'b0, 2'd1, 32'h0004_07FC},  // dev7 fn7 reg63
    '{32'h0004_1001, 1'b1, 2'd2, 32'h0004_1001},  // bus4 forwarded
    '{32'h0006_F8A5, 1'b0, 2'd2, 32'h0006_F8A5},  // bus6 = sub, forwarded
    '{32'h0007_0001, 1'b0, 2'd0, 32'h0},          // bus7 above sub
    '{32'h0002_0001, 1'b1, 2'd0, 32'h0},          // bus2 below sec
    '{32'h0003_A801, 1'b0, 2'd3, 32'h0},          // dev21 read
    '{32'h0003_F801, 1'b1, 2'd3, 32'h0},          // dev31 write
    '{32'h0004_0000, 1'b0, 2'd0, 32'h0},          // bad format 00
    '{32'h0003_2803, 1'b0, 2'd0, 32'h0},          // bad format 11
    '{32'h0005_0C09, 1'b0, 2'd2, 32'h0005_0C09}   // bus5 forwarded
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sec_bus = 8'd3;
  logic [7:0]  sub_bus = 8'd6;
  logic        up_req_valid = 1'b0;
  logic        up_req_ready;
  logic [31:0] up_req_addr = '0;
  logic        up_req_write = 1'b0;
  logic [31:0] up_req_wdata = '0;
  logic        up_rsp_valid;
  logic        up_rsp_ready = 1'b0;
  logic [31:0] up_rsp_rdata;
  logic        dn_req_valid;
  logic        dn_req_ready = 1'b0;
  logic [31:0] dn_req_addr;
  logic        dn_req_type1;
  logic        dn_req_write;
  logic [31:0] dn_req_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic        dn_rsp_ready;
  logic [31:0] dn_rsp_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_xlate_top u_dut (
    .clk(clk), .rst_n(rst_n), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
    .up_req_addr(up_req_addr), .up_req_write(up_req_write),
    .up_req_wdata(up_req_wdata), .up_rsp_valid(up_rsp_valid),
    .up_rsp_ready(up_rsp_ready), .up_rsp_rdata(up_rsp_rdata),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
    .dn_req_addr(dn_req_addr), .dn_req_type1(dn_req_type1),
    .dn_req_write(dn_req_write), .dn_req_wdata(dn_req_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready),
    .dn_rsp_rdata(dn_rsp_rdata)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_rsp(input logic [31:0] exp_data, input string req);
    chk(up_rsp_valid == 1'b1, "R9 rsp valid", 32'(up_rsp_valid), 32'd1);
    chk(up_rsp_rdata == exp_data, req, up_rsp_rdata, exp_data);
    chk(up_req_ready == 1'b0, "R8 busy in resp", 32'(up_req_ready), 32'd0);
    @(negedge clk);
    chk(up_rsp_valid && up_rsp_rdata == exp_data, "R10 rsp hold", up_rsp_rdata, exp_data);
    up_rsp_ready = 1'b1;
    @(negedge clk);
    up_rsp_ready = 1'b0;
    chk(up_rsp_valid == 1'b0, "R8 rsp done", 32'(up_rsp_valid), 32'd0);
    chk(up_req_ready == 1'b1, "R8 ready back", 32'(up_req_ready), 32'd1);
  endtask

  task automatic run_req(input logic [31:0] addr, input logic wr, input logic [1:0] kind,
                         input logic [31:0] exp_addr, input logic [31:0] wdata,
                         input logic [31:0] rdata);
    up_req_addr  = addr;
    up_req_write = wr;
    up_req_wdata = wdata;
    up_req_valid = 1'b1;
    @(negedge clk);
    up_req_valid = 1'b0;
    up_req_addr  = 32'hDEAD_BEEF;
    case (kind)
      2'd0: begin
        for (int k = 0; k < 3; k++) begin
          chk(!dn_req_valid && !up_rsp_valid, "R7 dropped",
              {30'd0, dn_req_valid, up_rsp_valid}, 32'd0);
          chk(up_req_ready == 1'b1, "R7 ready", 32'(up_req_ready), 32'd1);
          @(negedge clk);
        end
      end
      2'd3: begin
        chk(dn_req_valid == 1'b0, "R6 no downstream", 32'(dn_req_valid), 32'd0);
        finish_rsp(32'hFFFF_FFFF, "R6 all-ones data");
      end
      default: begin
        chk(up_req_ready == 1'b0, "R8 busy", 32'(up_req_ready), 32'd0);
        chk(dn_req_valid == 1'b1, "R2/R5 dn valid", 32'(dn_req_valid), 32'd1);
        chk(dn_req_addr == exp_addr, kind == 2'd1 ? "R3 type0 addr" : "R5 type1 addr",
            dn_req_addr, exp_addr);
        chk(dn_req_type1 == (kind == 2'd2), "R2 type flag", 32'(dn_req_type1),
            32'(kind == 2'd2));
        chk(dn_req_write == wr && dn_req_wdata == wdata, "R4 write payload",
            dn_req_wdata, wdata);
        @(negedge clk);
        chk(dn_req_valid && dn_req_addr == exp_addr, "R10 req hold", dn_req_addr, exp_addr);
        dn_req_ready = 1'b1;
        @(negedge clk);
        dn_req_ready = 1'b0;
        chk(!dn_req_valid && dn_rsp_ready, "R9 waiting", {30'd0, dn_req_valid, dn_rsp_ready},
            32'd1);
        dn_rsp_rdata = rdata;
        dn_rsp_valid = 1'b1;
        @(negedge clk);
        dn_rsp_valid = 1'b0;
        dn_rsp_rdata = '0;
        chk(dn_rsp_ready == 1'b0, "R9 rsp taken", 32'(dn_rsp_ready), 32'd0);
        finish_rsp(rdata, "R9 rsp data");
      end
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(up_req_ready == 1'b1, "R1 ready", 32'(up_req_ready), 32'd1);
    chk(!dn_req_valid && !up_rsp_valid && !dn_rsp_ready, "R1 idle outputs",
        {29'd0, dn_req_valid, up_rsp_valid, dn_rsp_ready}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      run_req(VECS[i].addr, VECS[i].wr, VECS[i].kind, VECS[i].exp_addr,
              32'h5A00_0000 + 32'(i), 32'hC0DE_0000 + 32'(i));
    end

    // R3 corner: secondary bus 0, device 0, all function/register bits set
    sec_bus = 8'd0;
    sub_bus = 8'd0;
    @(negedge clk);
    run_req(32'h0000_07FD, 1'b0, 2'd1, 32'h0000_0FFC, 32'h1, 32'hA5A5_A5A5);
    // R5 corner: bus 1 with sub 0 is outside the window -> dropped (R7)
    run_req(32'h0001_0001, 1'b0, 2'd0, 32'h0, 32'h0, 32'h0);
    // R2 corner: top bus number 255 as secondary, device 19 -> bit 30
    sec_bus = 8'hFF;
    sub_bus = 8'hFF;
    @(negedge clk);
    run_req(32'h00FF_9901, 1'b1, 2'd1, 32'h4000_0100, 32'h7777_0000, 32'h0BAD_F00D);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule